// File: doc/BRIEF.md
# Load-Use Stall and Bubble Controller

This block sits in the decode stage of a five-stage in-order pipeline. It decodes the opcode of the instruction held in the fetch/decode register into the control bits used by the later stages. These are the execute-stage bits (destination select, ALU operation class, ALU operand select), the memory-stage bits (branch, memory read, memory write) and the write-back bits (register write, memory-to-register select). The decoded bits are latched into the decode/execute control-field register on every clock.

Each cycle the block compares the instruction that is now in execute with the one in decode. If the execute-stage instruction reads memory and its Rt register names either source register of the decode-stage instruction, the result will not be ready in time. The block then holds the program counter and the fetch/decode register for one cycle by dropping their write enables. In the same cycle it loads an all-zero control field into decode/execute, which inserts a no-op bubble. On the next cycle the load has moved on, the stall clears, and the held instruction enters execute with its real controls. From there the forwarding network covers the rest of the dependency.

Top module: `load_use_stall`

## Requirements
- R1: `stall` is 1 exactly when the latched memory-read control bit (`ex_mem_read`) is 1 and `ex_rt` equals `dec_rs` or `dec_rt`. Register number 0 is not treated as a special case.
- R2: `pc_we` and `ifid_we` both equal the inverse of `stall`.
- R3: On the clock edge that ends a stall cycle, all nine control outputs are loaded with 0.
- R4: A stall never lasts more than one cycle in a row.
- R5: Opcode 6'h00 (register-register) latches dst_sel=1, alu_op=2'b10, alu_src=0, branch=0, mem_read=0, mem_write=0, reg_write=1, mem_to_reg=0.
- R6: Opcode 6'h23 (load) latches dst_sel=0, alu_op=2'b00, alu_src=1, branch=0, mem_read=1, mem_write=0, reg_write=1, mem_to_reg=1.
- R7: Opcode 6'h2b (store) latches alu_op=2'b00, alu_src=1, mem_write=1, and every other bit 0.
- R8: Opcode 6'h04 (branch) latches alu_op=2'b01, branch=1, and every other bit 0.
- R9: Any other opcode latches all-zero controls.
- R10: While `rst_n` is low, all control outputs are held at 0.
- R11: On the edge after a stall cycle, the held decode instruction's real controls are latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_op | input | 6 | Opcode of the instruction in fetch/decode |
| dec_rs | input | 5 | First source register of the decode instruction |
| dec_rt | input | 5 | Second source register of the decode instruction |
| ex_rt | input | 5 | Rt field of the instruction in execute |
| stall | output | 1 | Load-use hazard detected this cycle |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ex_dst_sel | output | 1 | Latched destination-register select |
| ex_alu_op | output | 2 | Latched ALU operation class |
| ex_alu_src | output | 1 | Latched ALU second-operand select |
| ex_branch | output | 1 | Latched branch flag |
| ex_mem_read | output | 1 | Latched memory-read flag |
| ex_mem_write | output | 1 | Latched memory-write flag |
| ex_reg_write | output | 1 | Latched register-write flag |
| ex_mem_to_reg | output | 1 | Latched write-back source select |

## Verification
The bench covers a dependence through Rs and another through Rt. A comparator missing one of them would let the dependent instruction through with no bubble. It also runs a load followed by an independent instruction, which must not stall, and a case where Rt matches but the execute instruction is not a load; a hazard check that ignored the memory-read gate would stall there by mistake. Chained loads check that the bubble lasts exactly one cycle and that the held instruction then gets its real decode. A design that re-stalled on its own bubble, or that latched zeros again after the stall, would hang the pipeline or lose that instruction.

// File: rtl/load_use_stall.sv
module load_use_stall #(
  parameter int OPW = 6,
  parameter int RW  = 5,
  parameter logic [OPW-1:0] OP_RR  = 6'h00,
  parameter logic [OPW-1:0] OP_LD  = 6'h23,
  parameter logic [OPW-1:0] OP_ST  = 6'h2b,
  parameter logic [OPW-1:0] OP_BR  = 6'h04
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] dec_op,
  input  logic [RW-1:0]  dec_rs,
  input  logic [RW-1:0]  dec_rt,
  input  logic [RW-1:0]  ex_rt,
  output logic           stall,
  output logic           pc_we,
  output logic           ifid_we,
  output logic           ex_dst_sel,
  output logic [1:0]     ex_alu_op,
  output logic           ex_alu_src,
  output logic           ex_branch,
  output logic           ex_mem_read,
  output logic           ex_mem_write,
  output logic           ex_reg_write,
  output logic           ex_mem_to_reg
);

  localparam int CW = 9;

  logic [CW-1:0] dec_ctrl;
  logic [CW-1:0] next_ctrl;
  logic [CW-1:0] ex_ctrl;

  always_comb begin
    case (dec_op)
      OP_RR:   dec_ctrl = 9'b1_10_0_0_0_0_1_0;
      OP_LD:   dec_ctrl = 9'b0_00_1_0_1_0_1_1;
      OP_ST:   dec_ctrl = 9'b0_00_1_0_0_1_0_0;
      OP_BR:   dec_ctrl = 9'b0_01_0_1_0_0_0_0;
      default: dec_ctrl = '0;
    endcase
  end

  assign stall   = ex_mem_read && ((ex_rt == dec_rs) || (ex_rt == dec_rt));
  assign pc_we   = !stall;
  assign ifid_we = !stall;

  assign next_ctrl = stall ? '0 : dec_ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) ex_ctrl <= '0;
    else        ex_ctrl <= next_ctrl;
  end

  assign {ex_dst_sel, ex_alu_op, ex_alu_src, ex_branch,
          ex_mem_read, ex_mem_write, ex_reg_write, ex_mem_to_reg} = ex_ctrl;

endmodule

module load_use_stall_chk #(
  parameter int OPW = 6,
  parameter int RW  = 5,
  parameter logic [OPW-1:0] OP_LD = 6'h23
) (
  input logic           clk,
  input logic           rst_n,
  input logic [OPW-1:0] dec_op,
  input logic [RW-1:0]  dec_rs,
  input logic [RW-1:0]  dec_rt,
  input logic [RW-1:0]  ex_rt,
  input logic           stall,
  input logic           pc_we,
  input logic           ifid_we,
  input logic           ex_dst_sel,
  input logic [1:0]     ex_alu_op,
  input logic           ex_alu_src,
  input logic           ex_branch,
  input logic           ex_mem_read,
  input logic           ex_mem_write,
  input logic           ex_reg_write,
  input logic           ex_mem_to_reg
);

  logic [8:0] ctrl;
  assign ctrl = {ex_dst_sel, ex_alu_op, ex_alu_src, ex_branch,
                 ex_mem_read, ex_mem_write, ex_reg_write, ex_mem_to_reg};

  assert_hazard_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_mem_read && (ex_rt == dec_rs || ex_rt == dec_rt)) |-> stall);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!pc_we && !ifid_we));

  assert_bubble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (ctrl == 9'd0));

  assert_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && dec_op == OP_LD) |=> (ex_mem_read && ex_mem_to_reg && ex_reg_write));

endmodule

bind load_use_stall load_use_stall_chk #(.OPW(OPW), .RW(RW), .OP_LD(OP_LD)) u_chk (.*);

// File: tb/load_use_stall_bench.sv
`timescale 1ns/1ps
module load_use_stall_bench;

  localparam logic [5:0] RR = 6'h00, LD = 6'h23, ST = 6'h2b, BR = 6'h04;
  localparam logic [8:0] C_RR = 9'b110000010;
  localparam logic [8:0] C_LD = 9'b000101011;
  localparam logic [8:0] C_ST = 9'b000100100;
  localparam logic [8:0] C_BR = 9'b001010000;

  logic clk = 0, rst_n = 0;
  logic [5:0] dec_op = '0;
  logic [4:0] dec_rs = '0, dec_rt = '0, ex_rt = '0;
  logic stall, pc_we, ifid_we;
  logic ex_dst_sel, ex_alu_src, ex_branch, ex_mem_read, ex_mem_write, ex_reg_write, ex_mem_to_reg;
  logic [1:0] ex_alu_op;
  logic [8:0] ctrl;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  load_use_stall u_load_use_stall (.*);

  assign ctrl = {ex_dst_sel, ex_alu_op, ex_alu_src, ex_branch,
                 ex_mem_read, ex_mem_write, ex_reg_write, ex_mem_to_reg};

  task automatic check(input logic ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt,
                      input logic [4:0] xrt, input logic exp_stall, input logic [8:0] exp_ctrl,
                      input string req);
    @(negedge clk);
    dec_op = op; dec_rs = rs; dec_rt = rt; ex_rt = xrt;
    #1;
    check(stall == exp_stall, {req, " R1 stall"}, 9'(stall), 9'(exp_stall));
    check(pc_we == !exp_stall && ifid_we == !exp_stall, "R2 enables",
          {7'd0, pc_we, ifid_we}, {7'd0, !exp_stall, !exp_stall});
    @(posedge clk); #1;
    check(ctrl == exp_ctrl, req, ctrl, exp_ctrl);
  endtask

  task automatic t_reset();
    dec_op = LD; dec_rs = 1; dec_rt = 1;
    repeat (3) @(posedge clk);
    #1;
    check(ctrl == 9'd0, "R10 reset", ctrl, 9'd0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_dep_rs();
    step(LD, 2, 1, 0, 0, C_LD, "R6 load");
    step(RR, 1, 5, 1, 1, 9'd0, "R3 bubble rs");
    step(RR, 1, 5, 1, 0, C_RR, "R11 held rr R5");
  endtask

  task automatic t_indep();
    step(LD, 2, 1, 5, 0, C_LD, "R6 load");
    step(RR, 3, 4, 1, 0, C_RR, "R1 no stall R5");
    step(RR, 1, 1, 1, 0, C_RR, "R1 no memread");
  endtask

  task automatic t_back_to_back();
    step(LD, 2, 1, 1, 0, C_LD, "R6 load a");
    step(LD, 1, 6, 1, 1, 9'd0, "R3 bubble ld-ld");
    step(LD, 1, 6, 1, 0, C_LD, "R4 single R11");
    step(RR, 6, 7, 6, 1, 9'd0, "R3 bubble after ld");
    step(RR, 6, 7, 6, 0, C_RR, "R4 single R11");
  endtask

  task automatic t_dep_rt();
    step(LD, 0, 3, 7, 0, C_LD, "R6 load");
    step(ST, 8, 3, 3, 1, 9'd0, "R3 bubble rt");
    step(ST, 8, 3, 3, 0, C_ST, "R7 store held");
  endtask

  task automatic t_decode();
    step(BR, 9, 10, 3, 0, C_BR, "R8 branch");
    step(6'h3f, 1, 2, 10, 0, 9'd0, "R9 unknown");
    step(6'h08, 1, 2, 2, 0, 9'd0, "R9 unknown");
    step(ST, 4, 5, 2, 0, C_ST, "R7 store");
  endtask

  initial begin
    t_reset();
    t_dep_rs();
    t_indep();
    t_back_to_back();
    t_dep_rt();
    t_decode();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog actual=%b expected=%b", 1'b1, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule